// File: doc/BRIEF.md
# Floppy Controller Host Register Block

This block is the byte-wide register file that a host processor sees on a two-drive floppy disk controller. A simple synchronous bus carries a 3-bit offset, a write strobe and a data byte. Read data is combinational on the cycle the access is presented. Side effects of reads and writes take place at the clock edge that ends the access.

The block holds several pieces of state: the drive-select and motor-enable controls, the boot-select bit, and the controller's sticky reset and sleep flags. It also drives the interrupt request line and holds its status code. Busy, transfer direction and command phase come from a separate command sequencer and are only reported here. Whenever the host triggers a controller reset, the sequencer gets a one-cycle `seqReset` pulse.

There are two ways for the host to reset the controller. Clearing the reset bit in the drive-control register puts the controller in a sticky reset state, which blocks most writes until that bit is written high again. Writing the rate register with its reset bit set performs a reset that clears itself at once. Both paths post an interrupt with status 0xC0. Reading the main status register clears the reset and sleep flags.

Top module: `flp_host_if`

## Requirements
- R1: After power-on reset, the controller is not in the reset state and is not asleep. Both motors are off, drive 0 is selected, boot-select is 0, the interrupt is low and `seqReset` is low.
- R2: A write to offset 2 (drive control) sets the drive 0 motor from bit 4, the drive 1 motor from bit 5 and the selected drive from bit 0. A read of offset 2 returns these bits in the same places, with bit 3 = `dmaEn`, bit 2 = not-in-reset and all other bits 0.
- R3: A write to offset 2 with bit 2 clear puts the controller in the reset state, and a read of offset 2 then shows bit 2 as 0.
- R4: While in the reset state, a write to offset 2 with bit 2 clear leaves the motors and the drive select unchanged.
- R5: While in the reset state, a write to offset 2 with bit 2 set has several effects. It leaves the reset state, clears sleep, pulses `seqReset` for one cycle, raises the interrupt with status 0xC0 and applies the written motor and drive-select bits.
- R6: Offset 3 stores a boot-select bit at bit 2. A read of offset 3 returns only that bit, with all other bits 0. Writes to offset 3 are ignored during reset.
- R7: A write to offset 4 with bit 7 set performs a self-clearing reset. It pulses `seqReset`, raises the interrupt with status 0xC0 and selects drive 0, and the controller does not stay in the reset state.
- R8: A write to offset 4 with bit 6 set sets the sleep flag and also performs a controller reset with the 0xC0 interrupt.
- R9: During the reset state, writes to offset 4 have no effect: they cause no interrupt, no `seqReset` pulse and no sleep.
- R10: A read of offset 4 returns the main status:
  - bit 7 is set when `seqBusy` is low;
  - bit 6 is set when `seqBusy` is low and `seqToHost` is high;
  - bit 4 equals `seqPhaseBusy`;
  - all other bits are 0.

  The read also clears the reset and sleep flags.
- R11: A read of offset 7 returns bit 7 = OR of `mediaChg`, with all other bits 0. Offsets 0, 1 and 6 read 0. Writes to offsets 0, 1, 6 and 7 have no effect.
- R12: The interrupt stays high once raised until `irqAck` clears it. A raise in the same cycle as `irqAck` leaves it high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| seqBusy | input | 1 | Sequencer busy |
| seqToHost | input | 1 | Transfer direction is controller to host |
| seqPhaseBusy | input | 1 | Sequencer in data or result phase |
| dmaEn | input | 1 | DMA enable indication for readback |
| mediaChg | input | 2 | Per-drive media-change flags |
| irqAck | input | 1 | Interrupt acknowledge |
| motorEn | output | 2 | Motor enables, index = drive |
| curDrive | output | 1 | Selected drive |
| bootSel | output | 1 | Boot-select bit |
| irqOut | output | 1 | Interrupt request |
| irqStatus | output | 8 | Status code held for the last raised interrupt |
| seqReset | output | 1 | One-cycle controller reset pulse to the sequencer |
| inReset | output | 1 | Controller is in the sticky reset state |
| sleepFlag | output | 1 | Sleep flag |

## Verification
The bench targets the sticky reset window. It checks that a drive-control write with the reset bit still low changes nothing, and that boot-select and rate writes are dropped there. A design that gates on the wrong bit would let the motors or drive select move, or would post a spurious interrupt. The bench also compares the two reset paths. The self-clearing rate reset must never leave the controller stuck in reset, while leaving the sticky reset must both pulse `seqReset` and post 0xC0. A status read must clear both flags as a side effect, and a raise must win over a simultaneous acknowledge. Getting any of these wrong shows up as a wrong bit 2 in the drive-control readback, a lingering sleep flag or a lost interrupt.

// File: rtl/flp_pkg.sv
package flp_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_STB  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_DOR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_BOOT = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_RATE = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 3'd7;

  localparam int DOR_RUN_BIT   = 2;
  localparam int DOR_DMA_BIT   = 3;
  localparam int DOR_MOTOR_LSB = 4;
  localparam int BOOT_BIT      = 2;
  localparam int RATE_RST_BIT  = 7;
  localparam int RATE_SLP_BIT  = 6;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrDor;   // apply drive-control write
    logic wrBoot;  // apply boot-select write
    logic ctlRst;  // controller reset + interrupt raise
  } flpStrobe_t;
endpackage

// File: rtl/flp_ctrl.sv
module flp_ctrl
  import flp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output flpStrobe_t        strobe,
  output logic              inReset,
  output logic              sleepFlag,
  output logic              seqReset
);
  logic wrAcc, rdAcc;
  logic unusedWd;

  assign wrAcc    = busSel & busWr;
  assign rdAcc    = busSel & ~busWr;
  assign unusedWd = ^{busWdata[5:3], busWdata[1:0]};

  always_comb begin
    strobe = '0;
    if (wrAcc) begin
      case (busAddr)
        OFS_DOR: begin
          if (!inReset || busWdata[DOR_RUN_BIT]) begin
            strobe.wrDor  = 1'b1;
            strobe.ctlRst = inReset & busWdata[DOR_RUN_BIT];
          end
        end
        OFS_BOOT: strobe.wrBoot = ~inReset;
        OFS_RATE: strobe.ctlRst = ~inReset &
                                  (busWdata[RATE_RST_BIT] | busWdata[RATE_SLP_BIT]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReset   <= 1'b0;
      sleepFlag <= 1'b0;
      seqReset  <= 1'b0;
    end else begin
      seqReset <= strobe.ctlRst;
      if (wrAcc && busAddr == OFS_DOR) begin
        if (!busWdata[DOR_RUN_BIT]) begin
          inReset <= 1'b1;
        end else if (inReset) begin
          inReset   <= 1'b0;
          sleepFlag <= 1'b0;
        end
      end else if (wrAcc && busAddr == OFS_RATE) begin
        if (!inReset && busWdata[RATE_SLP_BIT]) sleepFlag <= 1'b1;
      end else if (rdAcc && busAddr == OFS_RATE) begin
        inReset   <= 1'b0;
        sleepFlag <= 1'b0;
      end
    end
  end

  // R5
  leave_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inReset && wrAcc && busAddr == OFS_DOR && busWdata[DOR_RUN_BIT])
      |=> (!inReset && !sleepFlag && seqReset));

  // R7
  rate_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inReset && wrAcc && busAddr == OFS_RATE && busWdata[RATE_RST_BIT])
      |=> (!inReset && seqReset));

  // R9
  rate_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inReset && wrAcc && busAddr == OFS_RATE) |=> (!seqReset && $stable(sleepFlag)));

  // R10
  status_read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && busAddr == OFS_RATE) |=> (!inReset && !sleepFlag));
endmodule

// File: rtl/flp_datapath.sv
module flp_datapath
  import flp_pkg::*;
#(
  parameter int DRIVES = 2,
  parameter logic [DATA_W-1:0] RST_CODE = 8'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  flpStrobe_t        strobe,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              inReset,
  input  logic              seqBusy,
  input  logic              seqToHost,
  input  logic              seqPhaseBusy,
  input  logic              dmaEn,
  input  logic [DRIVES-1:0] mediaChg,
  input  logic              irqAck,
  output logic [DRIVES-1:0] motorEn,
  output logic              curDrive,
  output logic              bootSel,
  output logic              irqOut,
  output logic [DATA_W-1:0] irqStatus,
  output logic [DATA_W-1:0] busRdata
);
  localparam int MOTOR_MSB = DOR_MOTOR_LSB + DRIVES - 1;

  logic unusedWd;
  assign unusedWd = ^{busWdata[7:6], busWdata[3], busWdata[1]};

  for (genvar i = 0; i < DRIVES; i++) begin : g_motor
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             motorEn[i] <= 1'b0;
      else if (strobe.wrDor) motorEn[i] <= busWdata[DOR_MOTOR_LSB + i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curDrive  <= 1'b0;
      bootSel   <= 1'b0;
      irqOut    <= 1'b0;
      irqStatus <= '0;
    end else begin
      if (strobe.wrDor)       curDrive <= busWdata[0];
      else if (strobe.ctlRst) curDrive <= 1'b0;
      if (strobe.wrBoot) bootSel <= busWdata[BOOT_BIT];
      if (strobe.ctlRst) begin
        irqOut    <= 1'b1;
        irqStatus <= RST_CODE;
      end else if (irqAck) begin
        irqOut <= 1'b0;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWr) begin
      case (busAddr)
        OFS_DOR: begin
          busRdata[MOTOR_MSB:DOR_MOTOR_LSB] = motorEn;
          busRdata[DOR_DMA_BIT] = dmaEn;
          busRdata[DOR_RUN_BIT] = ~inReset;
          busRdata[0]           = curDrive;
        end
        OFS_BOOT: busRdata[BOOT_BIT] = bootSel;
        OFS_RATE: begin
          busRdata[7] = ~seqBusy;
          busRdata[6] = ~seqBusy & seqToHost;
          busRdata[4] = seqPhaseBusy;
        end
        OFS_DIN: busRdata[7] = |mediaChg;
        default: busRdata = '0;
      endcase
    end
  end

  // R4
  dor_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDor |-> (!inReset || busWdata[DOR_RUN_BIT]));

  // R6
  boot_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrBoot |-> !inReset);

  // R12
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctlRst |=> (irqOut && irqStatus == RST_CODE));

  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqAck) |=> irqOut);
endmodule

// File: rtl/flp_host_if.sv
module flp_host_if
  import flp_pkg::*;
#(
  parameter int DRIVES = 2,
  parameter logic [7:0] RST_CODE = 8'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [2:0]        busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              seqBusy,
  input  logic              seqToHost,
  input  logic              seqPhaseBusy,
  input  logic              dmaEn,
  input  logic [DRIVES-1:0] mediaChg,
  input  logic              irqAck,
  output logic [DRIVES-1:0] motorEn,
  output logic              curDrive,
  output logic              bootSel,
  output logic              irqOut,
  output logic [7:0]        irqStatus,
  output logic              seqReset,
  output logic              inReset,
  output logic              sleepFlag
);
  flpStrobe_t strobe;

  flp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .strobe(strobe),
    .inReset(inReset), .sleepFlag(sleepFlag), .seqReset(seqReset)
  );

  flp_datapath #(.DRIVES(DRIVES), .RST_CODE(RST_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .inReset(inReset),
    .seqBusy(seqBusy), .seqToHost(seqToHost), .seqPhaseBusy(seqPhaseBusy),
    .dmaEn(dmaEn), .mediaChg(mediaChg), .irqAck(irqAck),
    .motorEn(motorEn), .curDrive(curDrive), .bootSel(bootSel),
    .irqOut(irqOut), .irqStatus(irqStatus), .busRdata(busRdata)
  );
endmodule

// File: tb/sim_flp_host_if.sv
`timescale 1ns/1ps
module sim_flp_host_if;
  logic clk = 0, rstN = 0;
  logic busSel = 0, busWr = 0;
  logic [2:0] busAddr = 0;
  logic [7:0] busWdata = 0, busRdata;
  logic seqBusy = 0, seqToHost = 0, seqPhaseBusy = 0, dmaEn = 1, irqAck = 0;
  logic [1:0] mediaChg = 0, motorEn;
  logic curDrive, bootSel, irqOut, seqReset, inReset, sleepFlag;
  logic [7:0] irqStatus;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flp_host_if u0 (.*);

  task automatic chk(string req, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic doWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
  endtask

  task automatic doRead(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busSel = 0;
  endtask

  task automatic ackIrq();
    @(negedge clk); irqAck = 1;
    @(negedge clk); irqAck = 0;
  endtask

  task automatic tReset();
    logic [7:0] d;
    chk("R1 motors", motorEn, 0);
    chk("R1 drive", curDrive, 0);
    chk("R1 irq", irqOut, 0);
    chk("R1 inReset", inReset, 0);
    chk("R1 seqReset", seqReset, 0);
    doRead(3'd2, d); chk("R1 dor read", d, 8'h0C);
  endtask

  task automatic tDor();
    logic [7:0] d;
    doWrite(3'd2, 8'h35);
    chk("R2 motors", motorEn, 2'b11); chk("R2 drive", curDrive, 1);
    doRead(3'd2, d); chk("R2 read", d, 8'h3D);
    doWrite(3'd2, 8'h14);
    chk("R2 motors b", motorEn, 2'b01); chk("R2 drive b", curDrive, 0);
    dmaEn = 0;
    doRead(3'd2, d); chk("R2 read b", d, 8'h14);
    dmaEn = 1;
  endtask

  task automatic tStickyReset();
    logic [7:0] d;
    doWrite(3'd2, 8'h31);
    chk("R3 inReset", inReset, 1);
    doRead(3'd2, d); chk("R3 read", d, 8'h39);
    doWrite(3'd2, 8'h00);
    chk("R4 motors kept", motorEn, 2'b11); chk("R4 drive kept", curDrive, 1);
    doWrite(3'd3, 8'h04);
    doRead(3'd3, d); chk("R6 boot blocked", d, 8'h00);
    doWrite(3'd4, 8'hC0);
    chk("R9 no seqReset", seqReset, 0);
    chk("R9 no irq", irqOut, 0); chk("R9 no sleep", sleepFlag, 0);
    doWrite(3'd2, 8'h24);
    chk("R5 seqReset", seqReset, 1);
    chk("R5 irq", irqOut, 1); chk("R5 status", irqStatus, 8'hC0);
    chk("R5 out of reset", inReset, 0);
    chk("R5 motors", motorEn, 2'b10); chk("R5 drive", curDrive, 0);
    @(negedge clk); chk("R5 pulse ends", seqReset, 0);
    repeat (3) @(negedge clk);
    chk("R12 irq held", irqOut, 1);
    ackIrq(); chk("R12 ack clears", irqOut, 0);
  endtask

  task automatic tBoot();
    logic [7:0] d;
    doWrite(3'd3, 8'hFF);
    doRead(3'd3, d); chk("R6 read", d, 8'h04); chk("R6 out", bootSel, 1);
    doWrite(3'd3, 8'hFB);
    doRead(3'd3, d); chk("R6 clear", d, 8'h00);
  endtask

  task automatic tRate();
    logic [7:0] d;
    doWrite(3'd2, 8'h15);
    doWrite(3'd4, 8'h80);
    chk("R7 seqReset", seqReset, 1); chk("R7 irq", irqOut, 1);
    chk("R7 status", irqStatus, 8'hC0); chk("R7 drive0", curDrive, 0);
    chk("R7 not sticky", inReset, 0);
    doRead(3'd2, d); chk("R7 dor read", d, 8'h1C);
    ackIrq();
    doWrite(3'd4, 8'h40);
    chk("R8 sleep", sleepFlag, 1); chk("R8 irq", irqOut, 1);
    ackIrq();
    seqBusy = 0; seqToHost = 1; seqPhaseBusy = 1;
    doRead(3'd4, d); chk("R10 msr a", d, 8'hD0);
    chk("R10 sleep cleared", sleepFlag, 0);
    seqBusy = 1;
    doRead(3'd4, d); chk("R10 msr busy", d, 8'h10);
    seqBusy = 0; seqToHost = 0; seqPhaseBusy = 0;
    doRead(3'd4, d); chk("R10 msr idle", d, 8'h80);
    doWrite(3'd2, 8'h10);
    doRead(3'd4, d);
    chk("R10 reset cleared", inReset, 0);
    doRead(3'd2, d); chk("R10 dor bit2", d, 8'h1C);
    chk("R10 no irq", irqOut, 0);
  endtask

  task automatic tMisc();
    logic [7:0] d;
    mediaChg = 2'b00; doRead(3'd7, d); chk("R11 din 0", d, 8'h00);
    mediaChg = 2'b10; doRead(3'd7, d); chk("R11 din chg", d, 8'h80);
    mediaChg = 2'b00;
    doRead(3'd0, d); chk("R11 ofs0", d, 0);
    doRead(3'd1, d); chk("R11 ofs1", d, 0);
    doRead(3'd6, d); chk("R11 ofs6", d, 0);
    doWrite(3'd0, 8'hFF); doWrite(3'd1, 8'hFF);
    doWrite(3'd6, 8'h00); doWrite(3'd7, 8'hC0);
    doRead(3'd2, d); chk("R11 dor intact", d, 8'h1C);
    chk("R11 irq intact", irqOut, 0); chk("R11 boot intact", bootSel, 0);
    @(negedge clk); irqAck = 1; busSel = 1; busWr = 1; busAddr = 3'd4; busWdata = 8'h80;
    @(negedge clk); irqAck = 0; busSel = 0; busWr = 0;
    chk("R12 raise wins", irqOut, 1);
    ackIrq();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset(); tDor(); tStickyReset(); tBoot(); tRate(); tMisc();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule